// File: doc/BRIEF.md
# Multi-Scalar Tensor-Scalar Streaming ALU

This block takes a stream of 32-bit lanes that make up a four-axis tensor, ordered with the slice axis W outermost and then Z, Y and X. It combines every element with one scalar using a single bit-vector operation. The scalar comes from an eight-entry bank that is written beforehand through a small load port. The bank entry in use is the current W index, so the scalar changes each time a full Z·Y·X sub-volume has passed.

A command gives the shape, the operation code, the operand order and the element width. The command is accepted only while the block is idle. An illegal command is refused with a one-cycle reject pulse, and no elements are taken for it.

The datapath is a two-register pipeline with an ALU in each stage. Bank entries 0..3 are computed in the first stage and entries 4..7 in the second. A reversed command swaps the operands in both stages.

Top module: `mts_stream_alu`

## Requirements
- R1: A command whose W is outside 1..8, whose Z, Y or X is zero, or whose width code is 3, is refused: `cmd_reject` is high in the cycle after the handshake and no element is accepted.
- R2: An accepted command fixes the operation, order and width for all of its elements; `cmd_ready` is low until the last result has left, and `cmd_reject` stays low.
- R3: The n-th output (0-based, inputs in W,Z,Y,X order with X fastest) equals element n combined with bank entry floor(n / (Z·Y·X)).
- R4: Order code 0 places the element on the left and the scalar on the right; code 3 swaps them; codes 1 and 2 are refused.
- R5: Entries 0..3 are processed in the first stage and entries 4..7 in the second, and a reversed command swaps operands in both stages.
- R6: Operation codes (left operand L, right operand R): 0x00 pass L, 0x01 NOT L, 0x02 and 0x04 shift L left, 0x03 arithmetic shift L right, 0x05 logical shift L right, 0x06 AND, 0x08 OR, 0x09 XOR, 0x0A CRC32 step.
- R7: Codes 0x07, 0x1A and 0x1B, and every code not listed in R6, are refused.
- R8: Width code 0 means 8-bit elements, 1 means 16-bit and 2 means 32-bit; inputs are zero-extended to 32 bits and outputs are masked to the element width.
- R9: Exactly one output is produced per input, and the number of outputs equals W·Z·Y·X.
- R10: A bank write is ignored while `cmd_ready` is low. Reading an entry not written since reset yields zero and sets `stale_flag`, which stays set until reset.
- R11: Without backpressure, a result appears two cycles after its input handshake, at one element per cycle. A stalled output keeps its data and valid.
- R12: A shift uses R[4:0] as its amount. CRC32 takes L as the state and R[7:0] as the byte, XORs the byte in, then performs eight reflected shifts with polynomial 0xEDB88320.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | Scalar bank write strobe |
| ld_idx | input | 3 | Bank entry to write |
| ld_data | input | 32 | Scalar value |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and pipeline empty |
| cmd_w | input | 4 | Slice count W |
| cmd_z | input | DIM_W | Z extent |
| cmd_y | input | DIM_W | Y extent |
| cmd_x | input | DIM_W | X extent |
| cmd_op | input | 5 | Operation code |
| cmd_rev | input | 2 | Operand order code |
| cmd_ew | input | 2 | Element width code |
| cmd_reject | output | 1 | Pulse for a refused command |
| in_valid | input | 1 | Input element valid |
| in_ready | output | 1 | Input element accepted |
| in_data | input | 32 | Input element |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumer ready |
| out_data | output | 32 | Result element |
| stale_flag | output | 1 | Sticky unwritten-entry read flag |

## Verification
A slice counter that advances at the wrong point shows up as a scalar from the wrong bank entry. This appears at the output two cycles after the first misplaced element, so it is visible at the first Z·Y·X boundary of any command with W above one. An operand-order or stage-split fault corrupts results only for entries 4..7, or only for reversed commands. For that reason the sweeps cover every operation with both orders and every W up to eight. Counter or pipeline-valid faults show up as a wrong output count, or as `cmd_ready` failing to return once the last result has left.

// File: rtl/mts_pkg.sv
`timescale 1ns / 1ps
package mts_pkg;

  localparam int unsigned LANE_W = 32;
  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;

  typedef enum logic [4:0] {
    OP_PASS = 5'h00,
    OP_NOT  = 5'h01,
    OP_ASL  = 5'h02,
    OP_ASR  = 5'h03,
    OP_LSL  = 5'h04,
    OP_LSR  = 5'h05,
    OP_AND  = 5'h06,
    OP_OR   = 5'h08,
    OP_XOR  = 5'h09,
    OP_CRC  = 5'h0A
  } bv_op_e;

  localparam logic [1:0] REV_NONE = 2'd0;
  localparam logic [1:0] REV_BOTH = 2'd3;

  function automatic logic op_legal(input logic [4:0] op);
    case (op)
      OP_PASS, OP_NOT, OP_ASL, OP_ASR, OP_LSL,
      OP_LSR, OP_AND, OP_OR, OP_XOR, OP_CRC: op_legal = 1'b1;
      default:                               op_legal = 1'b0;
    endcase
  endfunction

  function automatic logic [LANE_W-1:0] lane_mask(input logic [1:0] ew);
    case (ew)
      2'd0:    lane_mask = 32'h0000_00FF;
      2'd1:    lane_mask = 32'h0000_FFFF;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [LANE_W-1:0] crc32_byte(input logic [LANE_W-1:0] state,
                                                   input logic [7:0] data);
    logic [LANE_W-1:0] c;
    c = state ^ {24'h0, data};
    for (int k = 0; k < 8; k++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
    end
    crc32_byte = c;
  endfunction

  function automatic logic [LANE_W-1:0] bv_alu(input logic [4:0] op,
                                               input logic [LANE_W-1:0] lhs,
                                               input logic [LANE_W-1:0] rhs);
    logic [4:0] sh;
    sh = rhs[4:0];
    case (op)
      OP_NOT:          bv_alu = ~lhs;
      OP_ASL, OP_LSL:  bv_alu = lhs << sh;
      OP_ASR:          bv_alu = $unsigned($signed(lhs) >>> sh);
      OP_LSR:          bv_alu = lhs >> sh;
      OP_AND:          bv_alu = lhs & rhs;
      OP_OR:           bv_alu = lhs | rhs;
      OP_XOR:          bv_alu = lhs ^ rhs;
      OP_CRC:          bv_alu = crc32_byte(lhs, rhs[7:0]);
      default:         bv_alu = lhs;
    endcase
  endfunction

endpackage

// File: rtl/mts_scalar_bank.sv
`timescale 1ns / 1ps
module mts_scalar_bank #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_data,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_data,
  output logic             rd_stale
);

  logic [31:0]      val_q [DEPTH];
  logic [DEPTH-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      for (int e = 0; e < DEPTH; e++) val_q[e] <= '0;
    end else if (wr_en) begin
      for (int e = 0; e < DEPTH; e++) begin
        if (wr_idx == IDX_W'(e)) begin
          val_q[e]  <= wr_data;
          seen_q[e] <= 1'b1;
        end
      end
    end
  end

  // Never-written entries still hold their reset value of zero.
  assign rd_data  = val_q[rd_idx];
  assign rd_stale = rd_en && !seen_q[rd_idx];

endmodule

// File: rtl/mts_axis_ctr.sv
`timescale 1ns / 1ps
module mts_axis_ctr #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] lim_in,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          at_end
);

  logic [CW-1:0] lim_q;
  logic [CW-1:0] cnt_q;

  assign at_end = (cnt_q == lim_q - CW'(1));
  assign cnt    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= CW'(1);
      cnt_q <= '0;
    end else if (load) begin
      lim_q <= lim_in;
      cnt_q <= '0;
    end else if (inc) begin
      cnt_q <= at_end ? '0 : cnt_q + CW'(1);
    end
  end

endmodule

// File: rtl/mts_loop_ctr.sv
`timescale 1ns / 1ps
module mts_loop_ctr #(
  parameter int unsigned CW   = 4,
  parameter int unsigned N_AX = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [N_AX-1:0][CW-1:0]  lim_in,
  input  logic                     step,
  output logic [CW-1:0]            outer_cnt,
  output logic                     last
);

  logic [N_AX-1:0] inc;
  logic [N_AX-1:0] at_end;
  logic [CW-1:0]   cnt_w [N_AX];

  assign inc[0] = step;

  for (genvar k = 0; k < N_AX; k++) begin : g_axis
    if (k > 0) begin : g_carry
      assign inc[k] = inc[k-1] && at_end[k-1];
    end
    mts_axis_ctr #(.CW(CW)) u_axis (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .lim_in (lim_in[k]),
      .inc    (inc[k]),
      .cnt    (cnt_w[k]),
      .at_end (at_end[k])
    );
  end

  assign outer_cnt = cnt_w[N_AX-1];
  assign last      = &at_end;

endmodule

// File: rtl/mts_alu_stage.sv
`timescale 1ns / 1ps
module mts_alu_stage
  import mts_pkg::*;
(
  input  logic [4:0]        op,
  input  logic              en,
  input  logic              rev,
  input  logic [LANE_W-1:0] elem,
  input  logic [LANE_W-1:0] scal,
  output logic [LANE_W-1:0] res
);

  always_comb begin
    if (!en)      res = elem;
    else if (rev) res = bv_alu(op, scal, elem);
    else          res = bv_alu(op, elem, scal);
  end

endmodule

// File: rtl/mts_stream_alu.sv
`timescale 1ns / 1ps
module mts_stream_alu
  import mts_pkg::*;
#(
  parameter int unsigned DIM_W      = 4,
  parameter int unsigned BANK_DEPTH = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ld_valid,
  input  logic [$clog2(BANK_DEPTH)-1:0] ld_idx,
  input  logic [31:0]                   ld_data,
  input  logic                          cmd_valid,
  output logic                          cmd_ready,
  input  logic [$clog2(BANK_DEPTH):0]   cmd_w,
  input  logic [DIM_W-1:0]              cmd_z,
  input  logic [DIM_W-1:0]              cmd_y,
  input  logic [DIM_W-1:0]              cmd_x,
  input  logic [4:0]                    cmd_op,
  input  logic [1:0]                    cmd_rev,
  input  logic [1:0]                    cmd_ew,
  output logic                          cmd_reject,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [31:0]                   in_data,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [31:0]                   out_data,
  output logic                          stale_flag
);

  localparam int unsigned IDX_W = $clog2(BANK_DEPTH);
  localparam int unsigned W_IN  = IDX_W + 1;
  localparam int unsigned CTR_W = (DIM_W > W_IN) ? DIM_W : W_IN;
  localparam int unsigned HALF  = BANK_DEPTH / 2;
  localparam int unsigned N_AX  = 4;

  // Command state
  logic       busy_q;
  logic [4:0] op_q;
  logic       rev_q;
  logic [1:0] ew_q;
  logic       reject_q;
  logic       stale_q;

  // Pipeline registers
  logic        p0_v, p1_v;
  logic        p0_hi, p1_hi;
  logic        p0_rev, p1_rev;
  logic [31:0] p0_elem, p0_scal;
  logic [31:0] p1_val, p1_scal;

  // Named internal events
  logic              cmd_ok, cmd_fire, cmd_take;
  logic              bank_we, in_fire;
  logic              p0_adv, p1_adv;
  logic              last_elem;
  logic [CTR_W-1:0]  slice_full;
  logic [IDX_W-1:0]  slice_idx;
  logic [31:0]       bank_rd_data;
  logic              bank_stale;
  logic              stage0_en, stage1_en;
  logic              stage0_rev, stage1_rev;
  logic [31:0]       stage0_res, stage1_res;
  logic [N_AX-1:0][CTR_W-1:0] lim_in;

  assign cmd_ok = (cmd_w != '0) && (cmd_w <= W_IN'(BANK_DEPTH)) &&
                  (cmd_z != '0) && (cmd_y != '0) && (cmd_x != '0) &&
                  op_legal(cmd_op) &&
                  ((cmd_rev == REV_NONE) || (cmd_rev == REV_BOTH)) &&
                  (cmd_ew != 2'd3);

  assign cmd_ready = !busy_q && !p0_v && !p1_v;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign cmd_take  = cmd_fire && cmd_ok;
  assign bank_we   = ld_valid && cmd_ready;

  assign p1_adv   = !p1_v || out_ready;
  assign p0_adv   = !p0_v || p1_adv;
  assign in_ready = busy_q && p0_adv;
  assign in_fire  = in_valid && in_ready;

  assign lim_in[0] = CTR_W'(cmd_x);
  assign lim_in[1] = CTR_W'(cmd_y);
  assign lim_in[2] = CTR_W'(cmd_z);
  assign lim_in[3] = CTR_W'(cmd_w);

  mts_loop_ctr #(.CW(CTR_W), .N_AX(N_AX)) u_loop (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cmd_take),
    .lim_in    (lim_in),
    .step      (in_fire),
    .outer_cnt (slice_full),
    .last      (last_elem)
  );

  assign slice_idx = slice_full[IDX_W-1:0];

  mts_scalar_bank #(.DEPTH(BANK_DEPTH), .IDX_W(IDX_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bank_we),
    .wr_idx   (ld_idx),
    .wr_data  (ld_data),
    .rd_en    (in_fire),
    .rd_idx   (slice_idx),
    .rd_data  (bank_rd_data),
    .rd_stale (bank_stale)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      op_q     <= OP_PASS;
      rev_q    <= 1'b0;
      ew_q     <= 2'd2;
      reject_q <= 1'b0;
      stale_q  <= 1'b0;
    end else begin
      reject_q <= cmd_fire && !cmd_ok;
      stale_q  <= stale_q || bank_stale;
      if (cmd_take) begin
        busy_q <= 1'b1;
        op_q   <= cmd_op;
        rev_q  <= (cmd_rev == REV_BOTH);
        ew_q   <= cmd_ew;
      end else if (in_fire && last_elem) begin
        busy_q <= 1'b0;
      end
    end
  end

  // Stage 0: entries in the lower half of the bank.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p0_v    <= 1'b0;
      p0_hi   <= 1'b0;
      p0_rev  <= 1'b0;
      p0_elem <= '0;
      p0_scal <= '0;
    end else if (p0_adv) begin
      p0_v <= in_fire;
      if (in_fire) begin
        p0_elem <= in_data & lane_mask(ew_q);
        p0_scal <= bank_rd_data;
        p0_hi   <= (slice_full >= CTR_W'(HALF));
        p0_rev  <= rev_q;
      end
    end
  end

  assign stage0_en  = p0_v && !p0_hi;
  assign stage0_rev = p0_rev;

  mts_alu_stage u_stage0 (
    .op   (op_q),
    .en   (stage0_en),
    .rev  (stage0_rev),
    .elem (p0_elem),
    .scal (p0_scal),
    .res  (stage0_res)
  );

  // Stage 1: entries in the upper half of the bank.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_v    <= 1'b0;
      p1_hi   <= 1'b0;
      p1_rev  <= 1'b0;
      p1_val  <= '0;
      p1_scal <= '0;
    end else if (p1_adv) begin
      p1_v <= p0_v;
      if (p0_v) begin
        p1_val  <= stage0_res;
        p1_scal <= p0_scal;
        p1_hi   <= p0_hi;
        p1_rev  <= p0_rev;
      end
    end
  end

  assign stage1_en  = p1_v && p1_hi;
  assign stage1_rev = p1_rev;

  mts_alu_stage u_stage1 (
    .op   (op_q),
    .en   (stage1_en),
    .rev  (stage1_rev),
    .elem (p1_val),
    .scal (p1_scal),
    .res  (stage1_res)
  );

  assign out_valid  = p1_v;
  assign out_data   = stage1_res & lane_mask(ew_q);
  assign cmd_reject = reject_q;
  assign stale_flag = stale_q;

endmodule

// File: rtl/mts_stream_alu_chk.sv
`timescale 1ns / 1ps
module mts_stream_alu_chk #(
  parameter int unsigned BANK_DEPTH = 8,
  parameter int unsigned W_IN       = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [W_IN-1:0] cmd_w,
  input logic [4:0]      cmd_op,
  input logic [1:0]      cmd_rev,
  input logic            cmd_reject,
  input logic            busy,
  input logic [4:0]      op_q,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [31:0]     out_data,
  input logic            p0_v,
  input logic            p1_v,
  input logic            stage0_rev,
  input logic            stage1_rev,
  input logic            bank_we,
  input logic            stale_flag
);

  logic [31:0] n_in, n_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_in  <= '0;
      n_out <= '0;
    end else begin
      if (in_valid && in_ready)   n_in  <= n_in + 32'd1;
      if (out_valid && out_ready) n_out <= n_out + 32'd1;
    end
  end

  assert_bad_w_rejected_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && ((cmd_w == '0) || (cmd_w > W_IN'(BANK_DEPTH))))
    |=> (cmd_reject && !busy));

  assert_op_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(op_q));

  assert_rev_mid_rejected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && ((cmd_rev == 2'd1) || (cmd_rev == 2'd2))) |=> cmd_reject);

  assert_rev_both_stages_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_v && p1_v) |-> (stage0_rev == stage1_rev));

  assert_banned_ops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready &&
     ((cmd_op == 5'h07) || (cmd_op == 5'h1A) || (cmd_op == 5'h1B))) |=> cmd_reject);

  assert_no_extra_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    n_out <= n_in);

  assert_counts_match_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (n_out == n_in));

  assert_bank_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |-> (!in_ready && !out_valid));

  assert_stale_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stale_flag |=> stale_flag);

  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

bind mts_stream_alu mts_stream_alu_chk #(
  .BANK_DEPTH (BANK_DEPTH),
  .W_IN       (W_IN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_w      (cmd_w),
  .cmd_op     (cmd_op),
  .cmd_rev    (cmd_rev),
  .cmd_reject (cmd_reject),
  .busy       (busy_q),
  .op_q       (op_q),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .p0_v       (p0_v),
  .p1_v       (p1_v),
  .stage0_rev (stage0_rev),
  .stage1_rev (stage1_rev),
  .bank_we    (bank_we),
  .stale_flag (stale_flag)
);

// File: tb/mts_stream_alu_tb.sv
`timescale 1ns / 1ps
module mts_stream_alu_tb;

  localparam int DW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic [2:0]  ld_idx = '0;
  logic [31:0] ld_data = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_w = '0;
  logic [DW-1:0] cmd_z = '0, cmd_y = '0, cmd_x = '0;
  logic [4:0]  cmd_op = '0;
  logic [1:0]  cmd_rev = '0, cmd_ew = '0;
  logic        cmd_reject;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        stale_flag;

  always #2.5 clk = ~clk;

  mts_stream_alu #(.DIM_W(DW), .BANK_DEPTH(8)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_data(ld_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_w(cmd_w), .cmd_z(cmd_z), .cmd_y(cmd_y), .cmd_x(cmd_x),
    .cmd_op(cmd_op), .cmd_rev(cmd_rev), .cmd_ew(cmd_ew), .cmd_reject(cmd_reject),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .stale_flag(stale_flag)
  );

  int errors = 0;
  int checks = 0;
  logic [31:0] sc [8];
  bit          wr [8];
  logic [15:0] lf = 16'hACE1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_mask(input int ew);
    return (ew == 0) ? 32'hFF : (ew == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  // Bit-serial reflected CRC: feed one data bit per step.
  function automatic logic [31:0] ref_crc(input logic [31:0] st, input logic [7:0] b);
    logic [31:0] c = st;
    for (int i = 0; i < 8; i++) begin
      logic fb = c[0] ^ b[i];
      c = (c >> 1) ^ (fb ? 32'hEDB8_8320 : 32'h0);
    end
    return c;
  endfunction

  function automatic logic [31:0] ref_alu(input int op, input logic [31:0] l, input logic [31:0] r);
    int s = int'(r[4:0]);
    logic [31:0] v;
    case (op)
      1:       v = ~l;
      2, 4:    v = l << s;
      3:       begin
                 v = l >> s;
                 if (l[31]) for (int k = 0; k < s; k++) v[31-k] = 1'b1;
               end
      5:       v = l >> s;
      6:       v = l & r;
      8:       v = l | r;
      9:       v = l ^ r;
      10:      v = ref_crc(l, r[7:0]);
      default: v = l;
    endcase
    return v;
  endfunction

  function automatic logic [31:0] elem_data(input int e, input int seed);
    logic [31:0] a = 32'(e) * 32'h9E37_79B9;
    return a ^ (32'(seed) * 32'h85EB_CA6B) ^ {8'(e), 24'h0};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; ld_valid = 0; cmd_valid = 0; in_valid = 0; out_ready = 1;
    for (int i = 0; i < 8; i++) begin sc[i] = '0; wr[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic load_scalar(input int idx, input logic [31:0] v);
    ld_valid = 1; ld_idx = 3'(idx); ld_data = v;
    @(negedge clk);
    ld_valid = 0;
    sc[idx] = v; wr[idx] = 1;
  endtask

  task automatic send_cmd(input int w, z, y, x, op, rev, ew, output bit rej, output bit rdy);
    cmd_w = 4'(w); cmd_z = DW'(z); cmd_y = DW'(y); cmd_x = DW'(x);
    cmd_op = 5'(op); cmd_rev = 2'(rev); cmd_ew = 2'(ew); cmd_valid = 1;
    #1 rdy = cmd_ready;
    @(negedge clk);
    cmd_valid = 0;
    rej = cmd_reject;
  endtask

  task automatic try_reject(input int w, z, y, x, op, rev, ew, input string req);
    bit rej, rdy;
    send_cmd(w, z, y, x, op, rev, ew, rej, rdy);
    chk(rdy && rej, req, {31'h0, rej}, 32'h1, "illegal command refused");
    chk(!in_ready && cmd_ready, req, {31'h0, in_ready}, 32'h0, "no element taken after refusal");
  endtask

  task automatic run_cmd(input int w, z, y, x, op, rev, ew, input bit bp, input bit poke,
                         input int seed, input string tag, output int iters);
    int n = w * z * y * x;
    int vol = z * y * x;
    int ii = 0;
    int oi = 0;
    bit rej, rdy, holding;
    logic [31:0] hold;
    holding = 0; hold = '0;
    send_cmd(w, z, y, x, op, rev, ew, rej, rdy);
    chk(rdy && !rej, "R2", {31'h0, rej}, 32'h0, "legal command accepted");
    iters = 0;
    while (oi < n && iters < 20000) begin
      if (bp) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        out_ready = (lf[1:0] != 2'b00);
      end else out_ready = 1;
      in_valid = (ii < n);
      in_data  = elem_data(ii, seed);
      ld_valid = poke && (iters == 1);
      ld_idx = 3'd0; ld_data = 32'hDEAD_BEEF;
      #1;
      if (holding) chk(out_valid && out_data == hold, "R11", out_data, hold, "stalled output held");
      holding = 0;
      if (out_valid) begin
        int si = oi / vol;
        logic [31:0] a = elem_data(oi, seed) & ref_mask(ew);
        logic [31:0] s = wr[si] ? sc[si] : 32'h0;
        logic [31:0] ex = ((rev == 3) ? ref_alu(op, s, a) : ref_alu(op, a, s)) & ref_mask(ew);
        string rq;
        if (tag != "") rq = tag;
        else if ((op >= 2 && op <= 5) || op == 10) rq = "R12";
        else if (ew != 2) rq = "R8";
        else if (si >= 4) rq = "R5";
        else if (rev == 3) rq = "R4";
        else if (op != 0) rq = "R6";
        else rq = "R3";
        if (out_ready) begin
          chk(out_data == ex, rq, out_data, ex, $sformatf("op %0h w%0d elem %0d", op, w, oi));
          oi++;
        end else begin
          holding = 1; hold = out_data;
        end
      end
      if (in_valid && in_ready) ii++;
      @(negedge clk);
      iters++;
    end
    in_valid = 0; ld_valid = 0; out_ready = 1;
    chk(ii == n && oi == n, "R9", 32'(oi), 32'(n), "one output per input");
    chk(cmd_ready, "R9", {31'h0, cmd_ready}, 32'h1, "ready after drain");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int ops[10] = '{0, 1, 2, 3, 4, 5, 6, 8, 9, 10};
    int it, k;
    do_reset();
    chk(cmd_ready && !out_valid && !in_ready, "R9", {29'h0, cmd_ready, out_valid, in_ready}, 32'h4, "reset state");
    chk(!stale_flag && !cmd_reject, "R10", {30'h0, stale_flag, cmd_reject}, 32'h0, "reset flags");

    // Unwritten entries read as zero and set the sticky flag.
    run_cmd(2, 1, 1, 2, 0, 3, 2, 0, 0, 1, "R10", it);
    chk(stale_flag, "R10", {31'h0, stale_flag}, 32'h1, "stale flag set");
    repeat (3) @(negedge clk);
    chk(stale_flag, "R10", {31'h0, stale_flag}, 32'h1, "stale flag sticky");
    do_reset();
    chk(!stale_flag, "R10", {31'h0, stale_flag}, 32'h0, "stale cleared by reset");

    load_scalar(0, 32'h0000_0003);
    load_scalar(1, 32'h8000_0011);
    load_scalar(2, 32'hFFFF_FF05);
    load_scalar(3, 32'h1234_567F);
    load_scalar(4, 32'h0000_001F);
    load_scalar(5, 32'hA5A5_0000);
    load_scalar(6, 32'h0F0F_F0F4);
    load_scalar(7, 32'h7FFF_FFE1);

    try_reject(0, 1, 1, 1, 0, 0, 2, "R1");
    try_reject(9, 1, 1, 1, 0, 0, 2, "R1");
    try_reject(2, 0, 1, 1, 0, 0, 2, "R1");
    try_reject(2, 1, 1, 0, 0, 0, 2, "R1");
    try_reject(2, 1, 1, 1, 0, 0, 3, "R1");
    try_reject(2, 1, 1, 1, 0, 1, 2, "R4");
    try_reject(2, 1, 1, 1, 0, 2, 2, "R4");
    try_reject(2, 1, 1, 1, 5'h07, 0, 2, "R7");
    try_reject(2, 1, 1, 1, 5'h1A, 0, 2, "R7");
    try_reject(2, 1, 1, 1, 5'h1B, 0, 2, "R7");
    try_reject(2, 1, 1, 1, 5'h0B, 0, 2, "R7");

    // Sweep: every operation, both orders, every width, W cycling 1..8.
    k = 0;
    foreach (ops[oi]) begin
      for (int rv = 0; rv < 2; rv++) begin
        for (int ew = 0; ew < 3; ew++) begin
          run_cmd(1 + (k % 8), 1 + (k % 2), 2, 3, ops[oi], rv * 3, ew, k[0], 0, k + 7, "", it);
          k++;
        end
      end
    end

    // Full-rate throughput: last result two cycles after last input.
    run_cmd(8, 2, 2, 2, 9, 3, 2, 0, 0, 99, "", it);
    chk(it == 8 * 2 * 2 * 2 + 2, "R11", 32'(it), 32'(8 * 2 * 2 * 2 + 2), "latency and throughput");

    // Bank write during a command is ignored.
    run_cmd(1, 1, 1, 2, 0, 0, 2, 0, 1, 5, "", it);
    run_cmd(1, 1, 1, 3, 0, 3, 2, 0, 0, 6, "R10", it);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule